// File: doc/BRIEF.md
# SPI Receive Sample-Phase Selector

This block is the receive capture stage of an SPI master. Each time the clock generator reports a nominal capture edge of SCK, the block takes one MISO bit into a shift register. At high bus rates the slave's output delay plus the round trip through the pads can push valid data past that nominal edge. To cover this, the capture point can be moved later by half an SCK period or by a full SCK period. Normal sampling suits bus clocks up to about 24 MHz. The half-period delay suits rates up to about 40 MHz. The full-period delay suits rates of 80 MHz and above.

The delay is made in the module-clock domain. The single-cycle capture strobe passes through a delay line whose taps sit `HALF_CYC` and `2*HALF_CYC` module clocks after the strobe, where `HALF_CYC` is the number of module clocks in one SCK half period. Bits are assembled MSB first. After every eighth captured bit the block presents the assembled word together with a one-clock valid pulse.

The sampling mode comes from two control bits. It is copied into the block only when the bus is quiet, so a byte is never split across two modes. While the bus is quiet the bit counter is also cleared, which throws away the bits of a byte that was cut short.

Top module: `spi_rx_phase_sel`

## Requirements
- R1: While `rst_n` is low and after it is released, `rx_valid` is 0 and `rx_byte` is all zeros until the first complete word has been captured.
- R2: Mode code {`cfg_sdm`,`cfg_sdc`} = 2'b10 selects normal sampling. The MISO value present in the cycle where `sck_cap_stb` is high is captured.
- R3: Mode code 2'b00 selects half-period delay. MISO is captured `HALF_CYC` module clocks after each `sck_cap_stb` pulse.
- R4: Mode code 2'b01 selects full-period delay. MISO is captured `2*HALF_CYC` module clocks after each `sck_cap_stb` pulse.
- R5: The reserved code 2'b11 behaves exactly like normal sampling.
- R6: Every `DATA_W` captures form one word. The first captured bit lands in `rx_byte[DATA_W-1]` (MSB first). Words follow each other with no gap in the bit stream.
- R7: `rx_valid` is high for exactly one module clock, in the cycle right after the capture of a word's last bit. `rx_byte` changes only in that cycle and holds its value otherwise.
- R8: The mode bits are loaded only when `bus_idle` is high, no delayed capture is pending and no strobe is present. Changes on `cfg_sdm`/`cfg_sdc` at other times have no effect on the word being received.
- R9: While the bus is quiet (the same condition as in R8), the bit counter and the partial word are cleared. Bits of an interrupted word never reach `rx_byte`.
- R10: In the delayed modes, the last bit of a word is still captured and reported when `bus_idle` rises right after the last `sck_cap_stb` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_idle | input | 1 | High when no transfer is in progress on the bus |
| sck_cap_stb | input | 1 | One-clock pulse at each nominal SCK capture edge |
| miso | input | 1 | Receive data from the slave, already synchronised |
| cfg_sdm | input | 1 | Mode bit: 1 selects normal sampling |
| cfg_sdc | input | 1 | Mode bit: with `cfg_sdm`=0, 1 selects full-period delay |
| rx_byte | output | DATA_W | Last complete received word, MSB first |
| rx_valid | output | 1 | One-clock pulse when `rx_byte` has been updated |

## Verification
MISO is driven with a pseudo-random bit per module clock. This makes the bits seen at the nominal edge, half a period later and a full period later almost always differ, so each mode can be told from the others by value alone. All four mode codes are swept over three strobe spacings: one SCK period, a stretched period, and a dense spacing that keeps several delayed strobes in flight at once. Each word is checked for both its value and the exact cycle of its valid pulse. Every transfer flips the mode pins after its first bit, which shows whether a change in the middle of a word leaks into capture. A transfer cut short after three bits, followed by a clean one, shows whether stale bits survive an idle gap.

// File: rtl/spi_rxp_pkg.sv
// Shared types for the SPI receive sample-phase selector.
// Assumes: the mode field is two bits, and the reserved code maps to nominal.
package spi_rxp_pkg;

    // Capture point relative to the nominal SCK capture edge
    typedef enum logic [1:0] {
        SMP_NOMINAL = 2'd0,
        SMP_HALF    = 2'd1,
        SMP_FULL    = 2'd2
    } smp_mode_e;

    // Map the two control bits onto a capture point; sdm wins over sdc
    function automatic smp_mode_e decode_mode(input logic sdm, input logic sdc);
        if (sdm) begin
            return SMP_NOMINAL;
        end else if (sdc) begin
            return SMP_FULL;
        end else begin
            return SMP_HALF;
        end
    endfunction

endpackage

// File: rtl/rxp_mode_latch.sv
// Holds the active sampling mode.
// Does: decodes the two control bits and stores the result on load.
// Assumes: load is high only while the bus is quiet, so a word never
// sees a mode change.
module rxp_mode_latch
    import spi_rxp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  logic      cfg_sdm,
    input  logic      cfg_sdc,
    output smp_mode_e mode_q
);

    smp_mode_e mode_next;

    // Decoded candidate mode from the pins
    always_comb begin
        mode_next = decode_mode(cfg_sdm, cfg_sdc);
    end

    // Take the new mode only when the caller allows it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SMP_NOMINAL;
        end else if (load) begin
            mode_q <= mode_next;
        end
    end

    // R8: without load the stored mode stays put
    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));

    // R5: the reserved code (sdm set) lands on nominal sampling
    p_reserved_nominal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cfg_sdm) |=> (mode_q == SMP_NOMINAL));

endmodule

// File: rtl/rxp_strobe_delay.sv
// Capture-strobe delay line.
// Does: shifts the nominal strobe through 2*HALF_CYC module-clock stages
// and picks the tap that matches the active mode.
// Assumes: HALF_CYC module clocks make one SCK half period; the strobe
// is one clock wide.
module rxp_strobe_delay
    import spi_rxp_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb,
    input  smp_mode_e mode,
    output logic      cap_en,
    output logic      pending
);

    localparam int DEPTH = 2 * HALF_CYC;

    logic [DEPTH-1:0] line_q;

    // Shift the nominal strobe one stage per module clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= {line_q[DEPTH-2:0], stb};
        end
    end

    // Choose the capture tap for the active mode
    always_comb begin
        case (mode)
            SMP_HALF: cap_en = line_q[HALF_CYC-1];
            SMP_FULL: cap_en = line_q[DEPTH-1];
            default:  cap_en = stb;
        endcase
    end

    // Any strobe still travelling down the line
    always_comb begin
        pending = |line_q;
    end

    // R10: a strobe always leaves a pending capture behind it
    p_strobe_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> pending);

endmodule

// File: rtl/rxp_shifter.sv
// Receive shift register and bit counter.
// Does: shifts MISO in MSB first on each capture and publishes a word
// with a one-clock valid after DATA_W captures.
// Assumes: clr is never high in a cycle that carries a capture.
module rxp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_en,
    input  logic              miso,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    localparam int               CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

    logic [DATA_W-2:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] word_next;
    logic              word_done;

    // Assemble the word that the current capture would complete
    always_comb begin
        word_next = {shreg_q, miso};
        word_done = cap_en && (cnt_q == LAST);
    end

    // Bit counter: cleared when quiet, wraps after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cap_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Partial-word shift register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg_q <= '0;
        end else if (cap_en) begin
            shreg_q <= word_next[DATA_W-2:0];
        end
    end

    // Output word and its one-clock valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= word_done;
            if (word_done) begin
                rx_byte <= word_next;
            end
        end
    end

    // R7: valid never lasts two clocks
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: the word holds whenever valid is low
    p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_byte));

    // R7: valid follows a capture by one clock
    p_valid_after_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cap_en));

    // R9: a quiet cycle never produces a word
    p_quiet_no_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rx_valid);

endmodule

// File: rtl/spi_rx_phase_sel.sv
// SPI receive sample-phase selector (top).
// Does: latches the sampling mode while the bus is quiet, delays the
// nominal capture strobe by zero, half or one SCK period and deserialises
// MISO MSB first into DATA_W-bit words.
// Assumes: miso is already synchronised to clk; sck_cap_stb is one clock
// wide; HALF_CYC matches the SCK half period in module clocks.
module spi_rx_phase_sel
    import spi_rxp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_idle,
    input  logic              sck_cap_stb,
    input  logic              miso,
    input  logic              cfg_sdm,
    input  logic              cfg_sdc,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_valid
);

    smp_mode_e mode_q;
    logic      cap_en;
    logic      pending;
    logic      quiet;

    // Bus quiet: idle, nothing in flight, no new strobe
    always_comb begin
        quiet = bus_idle && !pending && !sck_cap_stb;
    end

    rxp_mode_latch i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (quiet),
        .cfg_sdm (cfg_sdm),
        .cfg_sdc (cfg_sdc),
        .mode_q  (mode_q)
    );

    rxp_strobe_delay #(
        .HALF_CYC (HALF_CYC)
    ) i_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (sck_cap_stb),
        .mode    (mode_q),
        .cap_en  (cap_en),
        .pending (pending)
    );

    rxp_shifter #(
        .DATA_W (DATA_W)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (quiet),
        .cap_en   (cap_en),
        .miso     (miso),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    // R8: the mode never moves while a capture is still in flight
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(mode_q));

endmodule

// File: tb/test_spi_rx_phase_sel.sv
`timescale 1ns/1ps
module test_spi_rx_phase_sel;

    localparam int H = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_idle = 1'b1;
    logic         sck_cap_stb = 1'b0;
    logic         miso = 1'b0;
    logic         cfg_sdm = 1'b1;
    logic         cfg_sdc = 1'b0;
    logic [W-1:0] rx_byte;
    logic         rx_valid;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int       exp_cyc[$];
    logic [W-1:0] exp_byte[$];
    string    exp_tag[$];

    spi_rx_phase_sel #(.DATA_W(W), .HALF_CYC(H)) i_spi_rx_phase_sel (
        .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle),
        .sck_cap_stb(sck_cap_stb), .miso(miso),
        .cfg_sdm(cfg_sdm), .cfg_sdc(cfg_sdc),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic seqbit(input int i);
        logic [31:0] x;
        x = 32'(i) * 32'h9E3779B1;
        return x[17] ^ x[9];
    endfunction

    // MISO carries one pseudo-random bit per module clock
    always @(negedge clk) miso = seqbit(cyc);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: every valid pulse must match the next expected word and cycle (R6, R7)
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_cyc.size() == 0) begin
                check(1'b0, "R7 unexpected valid", int'(rx_byte), 0);
            end else begin
                check(cyc == exp_cyc[0], {exp_tag[0], " R7 valid cycle"}, cyc, exp_cyc[0]);
                check(rx_byte == exp_byte[0], {exp_tag[0], " R6 word"}, int'(rx_byte), int'(exp_byte[0]));
                void'(exp_cyc.pop_front());
                void'(exp_byte.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    function automatic int delay_of(input logic sdm, input logic sdc);
        if (sdm) return 0;
        else if (sdc) return 2 * H;
        else return H;
    endfunction

    function automatic string tag_of(input logic sdm, input logic sdc);
        if (sdm && sdc) return "R5";
        else if (sdm) return "R2";
        else if (sdc) return "R4";
        else return "R3";
    endfunction

    // Quiet period long enough to load the mode and drain the delay line
    task automatic quiet_gap(input logic sdm, input logic sdc);
        bus_idle = 1'b1;
        cfg_sdm = sdm;
        cfg_sdc = sdc;
        repeat (2 * H + 4) @(negedge clk);
    endtask

    // One transfer; pins flip after the first strobe to probe R8
    task automatic xfer(input logic sdm, input logic sdc, input int nbytes, input int gap);
        int d;
        logic [W-1:0] acc;
        string tag;
        d = delay_of(sdm, sdc);
        tag = {tag_of(sdm, sdc), "/R8"};
        acc = '0;
        quiet_gap(sdm, sdc);
        bus_idle = 1'b0;
        for (int i = 0; i < nbytes * W; i++) begin
            sck_cap_stb = 1'b1;
            acc = {acc[W-2:0], seqbit(cyc + d)};
            if ((i % W) == W - 1) begin
                exp_cyc.push_back(cyc + d + 1);
                exp_byte.push_back(acc);
                exp_tag.push_back(tag);
            end
            @(negedge clk);
            sck_cap_stb = 1'b0;
            if (i == 0) begin
                cfg_sdm = ~sdm;
                cfg_sdc = ~sdc;
            end
            repeat (gap - 1) @(negedge clk);
        end
        // Bus goes idle at once; delayed last bit must still arrive (R10)
        bus_idle = 1'b1;
        repeat (3 * H + 6) @(negedge clk);
        check(exp_cyc.size() == 0, "R10 words outstanding", exp_cyc.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(rx_valid == 1'b0, "R1 valid in reset", int'(rx_valid), 0);
        check(rx_byte == '0, "R1 word in reset", int'(rx_byte), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rx_valid == 1'b0, "R1 valid after reset", int'(rx_valid), 0);
        check(rx_byte == '0, "R1 word after reset", int'(rx_byte), 0);

        // Sweep all mode codes over three strobe spacings (R2 R3 R4 R5 R6)
        for (int code = 0; code < 4; code++) begin
            for (int g = 0; g < 3; g++) begin
                int gap;
                gap = (g == 0) ? 2 * H : ((g == 1) ? 2 * H + 3 : 3);
                xfer(code[1], code[0], 3, gap);
            end
        end

        // R9: three bits then idle; the partial word must vanish
        quiet_gap(1'b1, 1'b0);
        bus_idle = 1'b0;
        for (int i = 0; i < 3; i++) begin
            sck_cap_stb = 1'b1;
            @(negedge clk);
            sck_cap_stb = 1'b0;
            repeat (2 * H - 1) @(negedge clk);
        end
        bus_idle = 1'b1;
        repeat (2 * H + 4) @(negedge clk);
        check(exp_cyc.size() == 0, "R9 no word from partial", exp_cyc.size(), 0);
        xfer(1'b0, 1'b1, 1, 2 * H);
        xfer(1'b0, 1'b0, 2, 2 * H);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule